// File: doc/BRIEF.md
# Parity-Guarded Sequencer with State Watchdog

This block wraps a five-state binary-encoded sequencer with integrity protection. Three raw control requests (start, advance, cancel) arrive from outside the clock domain and each goes through a two-stage synchronizer before the transition logic sees it. The sequencer walks IDLE, ARMED, RUNNING, PAUSED and FINISHED. Any state code or input combination without an explicit rule sends it back to IDLE.

An even-parity bit is computed from the next-state value and registered on the same edge as the state. A monitor samples the stored state against its parity once every ten clock cycles. A single failing sample, or two in a row, are tolerated. A passing sample clears the failure run. The third consecutive failing sample forces the sequencer back to IDLE, restarts the sampling interval and raises a one-cycle watchdog flag.

A fault-injection mask lets a test flip the stored parity bit, or stored state bits, for one update. This exercises the guard without touching the RTL.

Top module: `fsm_guard`

## Requirements
- R1: A synchronous active-high reset puts the state at IDLE (code 0), clears the output vector and the watchdog flag, and starts the ten-cycle sampling interval from zero.
- R2: Each raw input passes through two flip-flops. A request held for one cycle changes the state on the third rising edge after it is applied, and not earlier.
- R3: The state codes are IDLE=0, ARMED=1, RUNNING=2, PAUSED=3 and FINISHED=4. The input bits are start=bit0, advance=bit1 and cancel=bit2. The transitions are: IDLE to ARMED on start. ARMED to RUNNING on advance. RUNNING to PAUSED on advance. PAUSED to FINISHED on start. FINISHED to IDLE unconditionally. In every other case the state holds.
- R4: Cancel in ARMED, RUNNING or PAUSED returns the state to IDLE and wins over any other input. Codes 5 to 7 have no rule and go to IDLE on the next clock.
- R5: The output vector decodes the registered state: bit0 is ARMED, bit1 is RUNNING or PAUSED, bit2 is PAUSED and bit3 is FINISHED.
- R6: Even parity over the next state is stored with it on every update. Bit 3 of the fault mask flips the stored parity for that one update. Bits 2:0 flip the stored state bits.
- R7: Consistency is sampled only in the tenth cycle of each interval, counted from reset or from the last watchdog reset. A mismatch present only in other cycles is never counted.
- R8: One or two consecutive failing samples cause no watchdog action. A passing sample clears the failure run.
- R9: The third consecutive failing sample returns the state to IDLE on the next cycle. It holds the watchdog flag high for exactly one cycle and restarts the interval and the failure run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 3 | Unsynchronized requests: start, advance, cancel |
| inj_mask | input | 4 | Fault mask: bit 3 flips stored parity, bits 2:0 flip stored state |
| state_o | output | 3 | Registered sequencer state code |
| out_o | output | 4 | Decoded output vector |
| wdog_rst_o | output | 1 | One-cycle pulse when the watchdog forces a reset |

## Verification
A table of one-cycle request pulses drives the sequencer through every legal arc. The table also covers ignored requests, and cancel presented together with advance, which separates the priority order from plain holding. A directed pulse is sampled one edge at a time to pin the synchronizer latency. A state-bit flip into code 6 shows that unused codes fall back to IDLE.

Parity flips placed off the sampling cycle are used to confirm that only the tenth cycle counts. Flips placed on the sampling cycle, in runs of one, two and three and with a clean sample between runs, separate a correct consecutive count from a cumulative one. A second run right after a watchdog reset fires only if the interval restarted.

// File: rtl/fsm_guard_pkg.sv
package fsm_guard_pkg;

    localparam int STATE_W = 3;
    localparam int IN_W    = 3;
    localparam int OUT_W   = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_RUN    = 3'd2,
        ST_PAUSED = 3'd3,
        ST_DONE   = 3'd4
    } state_e;

    // synchronized requests, start is bit 0
    typedef struct packed {
        logic cancel;
        logic advance;
        logic start;
    } req_t;

    typedef struct packed {
        logic done;
        logic paused;
        logic busy;
        logic armed;
    } out_t;

    function automatic logic even_par(input logic [STATE_W-1:0] s);
        return ^s;
    endfunction

    // explicit rules only; anything unmatched lands in IDLE
    function automatic logic [STATE_W-1:0] next_state(input logic [STATE_W-1:0] cur,
                                                      input req_t r);
        logic [STATE_W-1:0] nxt;
        nxt = ST_IDLE;
        case (cur)
            ST_IDLE:   nxt = r.start ? ST_ARMED : ST_IDLE;
            ST_ARMED:  if (r.cancel)       nxt = ST_IDLE;
                       else if (r.advance) nxt = ST_RUN;
                       else                nxt = ST_ARMED;
            ST_RUN:    if (r.cancel)       nxt = ST_IDLE;
                       else if (r.advance) nxt = ST_PAUSED;
                       else                nxt = ST_RUN;
            ST_PAUSED: if (r.cancel)       nxt = ST_IDLE;
                       else if (r.start)   nxt = ST_DONE;
                       else                nxt = ST_PAUSED;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic out_t decode_out(input logic [STATE_W-1:0] s);
        out_t o;
        o.armed  = (s == ST_ARMED);
        o.busy   = (s == ST_RUN) || (s == ST_PAUSED);
        o.paused = (s == ST_PAUSED);
        o.done   = (s == ST_DONE);
        return o;
    endfunction

endpackage

// File: rtl/fsm_guard_sync.sv
module fsm_guard_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/fsm_guard_core.sv
module fsm_guard_core
    import fsm_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  req_t               req,
    input  logic [STATE_W:0]   inj_mask,
    input  logic               wdog_fire,
    output logic [STATE_W-1:0] state_q,
    output logic               par_q
);
    logic [STATE_W-1:0] nxt;

    assign nxt = next_state(state_q, req);

    always_ff @(posedge clk) begin
        if (rst || wdog_fire) begin
            state_q <= ST_IDLE;
            par_q   <= even_par(ST_IDLE);
        end else begin
            {par_q, state_q} <= {even_par(nxt), nxt} ^ inj_mask;
        end
    end

    // R6: without injection the stored pair is always consistent
    p_parity_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (inj_mask == '0) |=> (par_q == ^state_q));

    // R4: unused codes fall back to IDLE
    p_unused_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q > ST_DONE && inj_mask == '0) |=> (state_q == ST_IDLE));

    // R4: cancel wins in the active states
    p_cancel_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (req.cancel && state_q != ST_IDLE && state_q <= ST_DONE && inj_mask == '0)
        |=> (state_q == ST_IDLE));
endmodule

// File: rtl/fsm_guard_monitor.sv
module fsm_guard_monitor
    import fsm_guard_pkg::*;
#(
    parameter int CHECK_INTERVAL = 10,
    parameter int FAIL_LIMIT     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] state_q,
    input  logic               par_q,
    output logic               wdog_fire,
    output logic               wdog_q
);
    localparam int CNT_W  = (CHECK_INTERVAL > 1) ? $clog2(CHECK_INTERVAL) : 1;
    localparam int FAIL_W = $clog2(FAIL_LIMIT + 1);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(CHECK_INTERVAL - 1);
    localparam logic [FAIL_W-1:0] FAIL_MAX = FAIL_W'(FAIL_LIMIT);

    logic [CNT_W-1:0]  cnt_q;
    logic [FAIL_W-1:0] fail_q;
    logic              sample;
    logic              mismatch;

    assign sample    = (cnt_q == LAST_CNT);
    assign mismatch  = (par_q != even_par(state_q));
    assign wdog_fire = sample && mismatch && (fail_q == FAIL_MAX);

    always_ff @(posedge clk) begin
        if (rst || wdog_fire) begin
            cnt_q  <= '0;
            fail_q <= '0;
        end else begin
            cnt_q <= sample ? '0 : cnt_q + CNT_W'(1);
            if (sample) fail_q <= mismatch ? fail_q + FAIL_W'(1) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wdog_q <= 1'b0;
        else     wdog_q <= wdog_fire;
    end

    // R8: the failure run never passes the limit
    p_fail_bound_r8: assert property (@(posedge clk) disable iff (rst)
        fail_q <= FAIL_MAX);

    // R7: the failure run only moves on a sampling cycle
    p_fail_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST_CNT) |=> $stable(fail_q));

    // R9: the flag is a single-cycle pulse
    p_wdog_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        wdog_q |=> !wdog_q);

    // R9: interval and failure run restart with the flag
    p_wdog_clear_r9: assert property (@(posedge clk) disable iff (rst)
        wdog_q |-> (cnt_q == '0 && fail_q == '0));
endmodule

// File: rtl/fsm_guard.sv
module fsm_guard
    import fsm_guard_pkg::*;
#(
    parameter int CHECK_INTERVAL = 10,
    parameter int FAIL_LIMIT     = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IN_W-1:0]    raw_in,
    input  logic [STATE_W:0]   inj_mask,
    output logic [STATE_W-1:0] state_o,
    output logic [OUT_W-1:0]   out_o,
    output logic               wdog_rst_o
);
    logic [IN_W-1:0]    sync_q;
    req_t               req;
    logic [STATE_W-1:0] state_q;
    logic               par_q;
    logic               wdog_fire;

    fsm_guard_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_in),
        .dout(sync_q)
    );

    assign req = req_t'(sync_q);

    fsm_guard_core u_core (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .inj_mask (inj_mask),
        .wdog_fire(wdog_fire),
        .state_q  (state_q),
        .par_q    (par_q)
    );

    fsm_guard_monitor #(.CHECK_INTERVAL(CHECK_INTERVAL), .FAIL_LIMIT(FAIL_LIMIT)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .state_q  (state_q),
        .par_q    (par_q),
        .wdog_fire(wdog_fire),
        .wdog_q   (wdog_rst_o)
    );

    assign state_o = state_q;
    assign out_o   = decode_out(state_q);

    // R9: the flag coincides with the forced IDLE state
    p_wdog_idle_r9: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_o |-> (state_o == ST_IDLE));

    // R5: outputs never claim two exclusive phases at once
    p_out_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_o[3], out_o[0], out_o[1]}));
endmodule

// File: tb/fsm_guard_bench.sv
module fsm_guard_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] raw_in = '0;
    logic [3:0] inj_mask = '0;
    logic [2:0] state_o;
    logic [3:0] out_o;
    logic       wdog_rst_o;

    int checks = 0;
    int fails  = 0;
    int phase  = 0;
    int mfail  = 0;
    bit bad    = 1'b0;
    bit exp_wd = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fsm_guard u_fsm_guard (
        .clk       (clk),
        .rst       (rst),
        .raw_in    (raw_in),
        .inj_mask  (inj_mask),
        .state_o   (state_o),
        .out_o     (out_o),
        .wdog_rst_o(wdog_rst_o)
    );

    // vector: {request[2:0], expected state[2:0]}; start=001 advance=010 cancel=100
    localparam logic [5:0] VEC [17] = '{
        {3'b000, 3'd0}, {3'b010, 3'd0}, {3'b001, 3'd1}, {3'b001, 3'd1},
        {3'b010, 3'd2}, {3'b010, 3'd3}, {3'b000, 3'd3}, {3'b001, 3'd4},
        {3'b000, 3'd0}, {3'b001, 3'd1}, {3'b100, 3'd0}, {3'b001, 3'd1},
        {3'b010, 3'd2}, {3'b110, 3'd0}, {3'b001, 3'd1}, {3'b010, 3'd2},
        {3'b001, 3'd2}
    };

    function automatic logic [3:0] exp_out(input logic [2:0] s);
        return {s == 3'd4, s == 3'd3, (s == 3'd2) || (s == 3'd3), s == 3'd1};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // one clock; model of the sampling interval and failure run
    task automatic tick();
        bit nb;
        bit fire;
        nb   = (inj_mask != '0);
        fire = 1'b0;
        @(posedge clk);
        if (rst) begin
            phase = 0; mfail = 0; bad = 1'b0;
        end else begin
            if (phase == 9) begin
                if (bad) begin
                    if (mfail == 2) fire = 1'b1;
                    else            mfail++;
                end else mfail = 0;
            end
            if (fire) begin
                phase = 0; mfail = 0; bad = 1'b0;
            end else begin
                phase = (phase + 1) % 10; bad = nb;
            end
        end
        exp_wd = fire;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; raw_in = '0; inj_mask = '0;
        tick();
        rst = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] r);
        raw_in = r;
        tick();
        raw_in = '0;
        tick();
        tick();
    endtask

    task automatic wait_phase(input int p);
        while (phase != p) tick();
    endtask

    // parity flip stored just before a sampling cycle, then the sampling edge
    task automatic inj_at_check(input string req);
        wait_phase(8);
        inj_mask = 4'b1000;
        tick();
        inj_mask = '0;
        tick();
        check(wdog_rst_o == exp_wd, req, wdog_rst_o, exp_wd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(state_o == 3'd0, "R1 state", state_o, 0);
        check(out_o == 4'd0, "R1 outputs", out_o, 0);
        check(wdog_rst_o == 1'b0, "R1 flag", wdog_rst_o, 0);

        // R3 R4 R5 transition table walk
        for (int i = 0; i < 17; i++) begin
            pulse(VEC[i][5:3]);
            check(state_o == VEC[i][2:0], "R3/R4 table state", state_o, VEC[i][2:0]);
            check(out_o == exp_out(VEC[i][2:0]), "R5 outputs", out_o, exp_out(VEC[i][2:0]));
        end

        // R2 synchronizer latency
        do_reset();
        raw_in = 3'b001;
        tick();
        raw_in = '0;
        check(state_o == 3'd0, "R2 edge1", state_o, 0);
        tick();
        check(state_o == 3'd0, "R2 edge2", state_o, 0);
        tick();
        check(state_o == 3'd1, "R2 edge3", state_o, 1);

        // R4 unused code falls back to IDLE
        do_reset();
        pulse(3'b001);
        pulse(3'b010);
        wait_phase(2);
        inj_mask = 4'b0100;
        tick();
        inj_mask = '0;
        check(state_o == 3'd6, "R6 state flip", state_o, 6);
        tick();
        check(state_o == 3'd0, "R4 unused code", state_o, 0);

        // R7 mismatches off the sampling cycle are never counted
        do_reset();
        for (int k = 0; k < 3; k++) begin
            wait_phase(3);
            inj_mask = 4'b1000;
            tick();
            inj_mask = '0;
            wait_phase(1);
            check(wdog_rst_o == 1'b0, "R7 off-sample flip", wdog_rst_o, 0);
        end

        // R8 tolerated runs and clearing by a clean sample
        do_reset();
        pulse(3'b001);
        pulse(3'b010);
        inj_at_check("R8 first fail");
        inj_at_check("R8 second fail");
        check(state_o == 3'd2, "R8 state kept", state_o, 2);
        wait_phase(9);
        tick();
        check(wdog_rst_o == 1'b0, "R8 clean sample", wdog_rst_o, 0);
        inj_at_check("R8 fail after clear");
        inj_at_check("R8 second fail after clear");
        check(state_o == 3'd2, "R8 state kept 2", state_o, 2);

        // R9 third consecutive failure
        inj_at_check("R9 third fail");
        check(wdog_rst_o == 1'b1, "R9 flag high", wdog_rst_o, 1);
        check(state_o == 3'd0, "R9 forced IDLE", state_o, 0);
        tick();
        check(wdog_rst_o == 1'b0, "R9 single pulse", wdog_rst_o, 0);

        // R9 interval restarts after the watchdog reset
        inj_at_check("R9 restart fail1");
        inj_at_check("R9 restart fail2");
        inj_at_check("R9 restart fail3");
        check(wdog_rst_o == 1'b1, "R9 restarted interval", wdog_rst_o, 1);

        summary();
    end
endmodule